// File: doc/BRIEF.md
# Multi-Port Aperiodic Event Status Collector

This block gathers sticky event flags for the control/indication and monitor channels of four serial line ports and drives one level interrupt. Each port raises four kinds of event: a control word has been received, the control transmit register has become empty, a monitor byte has been received, and the monitor transmit register has become empty. Each event sets a flag that stays set until software reads the register that the flag belongs to.

The receive flags of a port clear when that port's own receive register is read. The two kinds of transmit-empty flags work differently. All ports share one status register for control transmit and one for monitor transmit, and a read of either register clears that kind of flag on every port at once. Software sees all sixteen flags as one read-only status word through a simple read port, and reading that word changes nothing. A per-port enable nibble decides which flags can raise the interrupt.

Top module: `aps_collector`

## Requirements
- R1: After reset all sixteen flags are 0, `irq_o` is 0 and `stat_rdata_o` is 0.
- R2: Port n owns status bits 4n+3..4n, with port 3 in bits 15..12. Within a nibble, bit 3 is control received, bit 2 is control transmit empty, bit 1 is monitor received and bit 0 is monitor transmit empty. `irq_en_i` uses the same layout.
- R3: A one-cycle event pulse sets its flag at the next clock edge. The flag then holds until a clearing read arrives.
- R4: `ctrl_rx_rd_i[n]` clears only bit 4n+3, and `mon_rx_rd_i[n]` clears only bit 4n+1. No other bit changes.
- R5: `ctrl_tx_stat_rd_i` clears bit 2 of every port nibble, and `mon_tx_stat_rd_i` clears bit 0 of every port nibble. No other bit changes.
- R6: When an event and a clearing read for the same flag arrive in the same cycle, the flag ends up set.
- R7: `irq_o` is a register holding the OR of (flags AND `irq_en_i`). It follows that value one clock later and stays high while any enabled flag is set.
- R8: A 0 in an enable bit masks that flag from `irq_o`, but the flag stays set and can still be read.
- R9: A pulse on `stat_rd_i` loads the current flags into `stat_rdata_o` at the next edge. It has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctrl_rx_evt_i | input | 4 | Per-port pulse: control word received |
| ctrl_tx_evt_i | input | 4 | Per-port pulse: control transmit register empty |
| mon_rx_evt_i | input | 4 | Per-port pulse: monitor byte received |
| mon_tx_evt_i | input | 4 | Per-port pulse: monitor transmit register empty |
| irq_en_i | input | 16 | Interrupt enables, in the status word layout |
| ctrl_rx_rd_i | input | 4 | Per-port strobe: control receive register read |
| mon_rx_rd_i | input | 4 | Per-port strobe: monitor receive register read |
| ctrl_tx_stat_rd_i | input | 1 | Strobe: shared control transmit status read |
| mon_tx_stat_rd_i | input | 1 | Strobe: shared monitor transmit status read |
| stat_rd_i | input | 1 | Strobe: status word read |
| stat_rdata_o | output | 16 | Status word captured at the last read |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event that sets a flag and a read that clears it can fall in the same cycle. The bench provokes this by pulsing all sixteen event inputs together with every one of the 1024 combinations of the ten clearing strobes. Each time it reads the status word back and judges that every flag remained set. The same sweep, run without events, sets all flags first and then applies each strobe combination. It compares the surviving bits against a clear mask that the bench computes from the bit layout.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int unsigned EVT_W = 4;

  typedef enum int unsigned {
    SLOT_MON_TX  = 0,
    SLOT_MON_RX  = 1,
    SLOT_CTRL_TX = 2,
    SLOT_CTRL_RX = 3
  } slot_e;
endpackage

// File: rtl/aps_rst_sync.sv
module aps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/aps_route.sv
module aps_route
  import aps_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned STAT_W = NUM_PORTS * EVT_W
) (
  input  logic [NUM_PORTS-1:0] ctrl_rx_evt_i,
  input  logic [NUM_PORTS-1:0] ctrl_tx_evt_i,
  input  logic [NUM_PORTS-1:0] mon_rx_evt_i,
  input  logic [NUM_PORTS-1:0] mon_tx_evt_i,
  input  logic [NUM_PORTS-1:0] ctrl_rx_rd_i,
  input  logic [NUM_PORTS-1:0] mon_rx_rd_i,
  input  logic                 ctrl_tx_stat_rd_i,
  input  logic                 mon_tx_stat_rd_i,
  output logic [STAT_W-1:0]    set_vec_o,
  output logic [STAT_W-1:0]    clr_vec_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned BASE = p * EVT_W;
    assign set_vec_o[BASE + int'(SLOT_CTRL_RX)] = ctrl_rx_evt_i[p];
    assign set_vec_o[BASE + int'(SLOT_CTRL_TX)] = ctrl_tx_evt_i[p];
    assign set_vec_o[BASE + int'(SLOT_MON_RX)]  = mon_rx_evt_i[p];
    assign set_vec_o[BASE + int'(SLOT_MON_TX)]  = mon_tx_evt_i[p];

    assign clr_vec_o[BASE + int'(SLOT_CTRL_RX)] = ctrl_rx_rd_i[p];
    assign clr_vec_o[BASE + int'(SLOT_CTRL_TX)] = ctrl_tx_stat_rd_i;
    assign clr_vec_o[BASE + int'(SLOT_MON_RX)]  = mon_rx_rd_i[p];
    assign clr_vec_o[BASE + int'(SLOT_MON_TX)]  = mon_tx_stat_rd_i;
  end
endmodule

// File: rtl/aps_flag_bank.sv
module aps_flag_bank #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] flags_d;
  logic             upd_en;

  always_comb begin
    upd_en  = |(set_i | clr_i);
    flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

  // R3
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_o & ~clr_i)) |=>
      ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i)));
endmodule

// File: rtl/aps_irq.sv
module aps_irq #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] flags_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(flags_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_i & en_i)) |=> irq_o);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_i) == '0) |=> !irq_o);
endmodule

// File: rtl/aps_collector.sv
module aps_collector
  import aps_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned STAT_W = NUM_PORTS * EVT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] ctrl_rx_evt_i,
  input  logic [NUM_PORTS-1:0] ctrl_tx_evt_i,
  input  logic [NUM_PORTS-1:0] mon_rx_evt_i,
  input  logic [NUM_PORTS-1:0] mon_tx_evt_i,
  input  logic [STAT_W-1:0]    irq_en_i,
  input  logic [NUM_PORTS-1:0] ctrl_rx_rd_i,
  input  logic [NUM_PORTS-1:0] mon_rx_rd_i,
  input  logic                 ctrl_tx_stat_rd_i,
  input  logic                 mon_tx_stat_rd_i,
  input  logic                 stat_rd_i,
  output logic [STAT_W-1:0]    stat_rdata_o,
  output logic                 irq_o
);
  logic              rst_sync_n;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] flags;
  logic [STAT_W-1:0] rdata_q;
  logic [STAT_W-1:0] rdata_d;

  aps_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aps_route #(.NUM_PORTS(NUM_PORTS)) u_route (
    .ctrl_rx_evt_i     (ctrl_rx_evt_i),
    .ctrl_tx_evt_i     (ctrl_tx_evt_i),
    .mon_rx_evt_i      (mon_rx_evt_i),
    .mon_tx_evt_i      (mon_tx_evt_i),
    .ctrl_rx_rd_i      (ctrl_rx_rd_i),
    .mon_rx_rd_i       (mon_rx_rd_i),
    .ctrl_tx_stat_rd_i (ctrl_tx_stat_rd_i),
    .mon_tx_stat_rd_i  (mon_tx_stat_rd_i),
    .set_vec_o         (set_vec),
    .clr_vec_o         (clr_vec)
  );

  aps_flag_bank #(.WIDTH(STAT_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  aps_irq #(.WIDTH(STAT_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flags_i (flags),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_d = stat_rd_i ? flags : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign stat_rdata_o = rdata_q;

  // R9
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_rd_i |=> (stat_rdata_o == $past(flags)));

  // R9
  read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_rd_i && (set_vec == '0) && (clr_vec == '0)) |=> $stable(flags));

  // R5
  shared_tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_tx_stat_rd_i && (ctrl_tx_evt_i == '0)) |=>
      ((flags & {NUM_PORTS{4'b0100}}) == '0));
endmodule

// File: tb/aps_collector_tb.sv
`timescale 1ns/1ps
module aps_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ctrl_rx_evt, ctrl_tx_evt, mon_rx_evt, mon_tx_evt;
  logic [15:0] irq_en;
  logic [3:0]  ctrl_rx_rd, mon_rx_rd;
  logic        ctrl_tx_stat_rd, mon_tx_stat_rd, stat_rd;
  logic [15:0] stat_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aps_collector u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .ctrl_rx_evt_i     (ctrl_rx_evt),
    .ctrl_tx_evt_i     (ctrl_tx_evt),
    .mon_rx_evt_i      (mon_rx_evt),
    .mon_tx_evt_i      (mon_tx_evt),
    .irq_en_i          (irq_en),
    .ctrl_rx_rd_i      (ctrl_rx_rd),
    .mon_rx_rd_i       (mon_rx_rd),
    .ctrl_tx_stat_rd_i (ctrl_tx_stat_rd),
    .mon_tx_stat_rd_i  (mon_tx_stat_rd),
    .stat_rd_i         (stat_rd),
    .stat_rdata_o      (stat_rdata),
    .irq_o             (irq)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // strobe vector: [3:0] ctrl rx reads, [7:4] mon rx reads, [8] ctrl tx status, [9] mon tx status
  function automatic logic [15:0] clr_mask(input logic [9:0] s);
    logic [15:0] m = '0;
    for (int n = 0; n < 4; n++) begin
      m[4*n+3] = s[n];
      m[4*n+2] = s[8];
      m[4*n+1] = s[4+n];
      m[4*n]   = s[9];
    end
    return m;
  endfunction

  task automatic drive(input logic [15:0] ev, input logic [9:0] s);
    for (int n = 0; n < 4; n++) begin
      ctrl_rx_evt[n] = ev[4*n+3];
      ctrl_tx_evt[n] = ev[4*n+2];
      mon_rx_evt[n]  = ev[4*n+1];
      mon_tx_evt[n]  = ev[4*n];
    end
    ctrl_rx_rd      = s[3:0];
    mon_rx_rd       = s[7:4];
    ctrl_tx_stat_rd = s[8];
    mon_tx_stat_rd  = s[9];
    @(posedge clk); @(negedge clk);
    ctrl_rx_evt = '0; ctrl_tx_evt = '0; mon_rx_evt = '0; mon_tx_evt = '0;
    ctrl_rx_rd = '0; mon_rx_rd = '0; ctrl_tx_stat_rd = 1'b0; mon_tx_stat_rd = 1'b0;
  endtask

  task automatic read_stat(output logic [15:0] v);
    stat_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    stat_rd = 1'b0;
    v = stat_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0;
    ctrl_rx_evt = '0; ctrl_tx_evt = '0; mon_rx_evt = '0; mon_tx_evt = '0;
    ctrl_rx_rd = '0; mon_rx_rd = '0; ctrl_tx_stat_rd = 1'b0; mon_tx_stat_rd = 1'b0;
    stat_rd = 1'b0; irq_en = '0;
    repeat (3) @(negedge clk);
    check({15'd0, irq}, 16'd0, "R1 irq in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(stat_rdata, 16'h0000, "R1 rdata after reset");
    check({15'd0, irq}, 16'd0, "R1 irq after reset");
    read_stat(v);
    check(v, 16'h0000, "R1 flags after reset");

    // R2 R3 R7 R8 R9 single-bit sweep
    for (int b = 0; b < 16; b++) begin
      drive(16'(1) << b, '0);
      read_stat(v);
      check(v, 16'(1) << b, "R2 R3 bit position");
      read_stat(v);
      check(v, 16'(1) << b, "R9 repeat read unchanged");
      irq_en = 16'(1) << b;
      tick();
      check({15'd0, irq}, 16'd1, "R7 enabled flag raises irq");
      irq_en = ~(16'(1) << b);
      tick();
      check({15'd0, irq}, 16'd0, "R8 masked flag no irq");
      read_stat(v);
      check(v, 16'(1) << b, "R8 masked flag still set");
      irq_en = '0;
      drive('0, 10'h3FF);
      read_stat(v);
      check(v, 16'h0000, "R4 R5 full clear");
    end

    // R7 latency: flag after one edge, irq after the next
    irq_en = 16'hFFFF;
    ctrl_rx_evt = 4'b0100;
    @(posedge clk); @(negedge clk);
    ctrl_rx_evt = '0;
    check({15'd0, irq}, 16'd0, "R7 irq not yet at flag edge");
    tick();
    check({15'd0, irq}, 16'd1, "R7 irq one edge after flag");
    drive('0, 10'h3FF);
    tick();
    check({15'd0, irq}, 16'd0, "R7 irq drops after clear");
    irq_en = '0;

    // R4 R5 R6 strobe sweep
    for (int s = 0; s < 1024; s++) begin
      drive(16'hFFFF, '0);
      drive('0, 10'(s));
      read_stat(v);
      check(v, ~clr_mask(10'(s)), "R4 R5 selective clear");
      irq_en = 16'hFFFF;
      tick();
      check({15'd0, irq}, {15'd0, (~clr_mask(10'(s))) != 16'h0}, "R7 irq from survivors");
      irq_en = '0;
      drive('0, 10'h3FF);
      drive(16'hFFFF, 10'(s));
      read_stat(v);
      check(v, 16'hFFFF, "R6 set wins over clear");
      drive('0, 10'h3FF);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule